// File: doc/BRIEF.md
# Programmable Bitwise Logic Unit

This block applies any two-input Boolean function, bit by bit, to a pair of equal-width operands. Every bit position has its own four-input multiplexer. The two operand bits at that position drive the multiplexer selects, and a shared 4-bit function code drives its data inputs. The code is therefore the truth table of the chosen function, and all sixteen two-input functions are reachable without any fixed gate logic.

The unit is purely combinational and has no clock. The result follows the operands and the code directly. The package provides a decode function that turns named operations (AND, OR, XOR, NAND, NOR, XNOR, pass-through, inversions and constants) into their function codes. Callers that think in operations rather than truth tables can use it to drive the code input.

Top module: `mux_logic_unit`

## Requirements
- R1: In each bit slice, operand bit x drives the low select and operand bit y drives the high select. The result bit is code bit 0 for (x=0,y=0), code bit 1 for (x=1,y=0), code bit 2 for (x=0,y=1) and code bit 3 for (x=1,y=1).
- R2: The same code is applied to every slice. Result bit i depends only on x_i[i], y_i[i] and the code, for every one of the 16 code values.
- R3: Code 4'b1000 yields the bitwise AND of x_i and y_i, and the decode helper maps the AND operation to 4'b1000.
- R4: Code 4'b1110 yields the bitwise OR, and the decode helper maps the OR operation to 4'b1110.
- R5: Code 4'b0110 yields the bitwise XOR, and the decode helper maps the XOR operation to 4'b0110.
- R6: Code 4'b0111 yields the bitwise NAND, and the decode helper maps the NAND operation to 4'b0111.
- R7: Code 4'b0000 yields all zeros and code 4'b1111 yields all ones, whatever the operands.
- R8: Code 4'b1010 passes x_i unchanged and code 4'b1100 passes y_i unchanged.
- R9: The operand width is the parameter WIDTH (default 8). Behaviour is identical for other widths, including WIDTH=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand, drives the low select of each slice |
| y_i | input | WIDTH | Second operand, drives the high select of each slice |
| func_i | input | 4 | Function code, used as the truth table of the operation |
| res_o | output | WIDTH | Bitwise result |

## Verification
The hardest case to reach is one where every slice sees all four select combinations while a given code is applied. Without that, a swapped select or a misrouted data leg can stay hidden behind an operand pattern that never exercises it. A 4-bit instance is therefore driven through every operand pair under every code, which covers each select combination in every slice. The 8-bit instance gets random operand pairs under every code. It also gets the fixed patterns 8'h55 and 8'h33, which place all four (x,y) combinations within each nibble.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned LU_SEL_W  = 2;
  localparam int unsigned LU_CODE_W = 1 << LU_SEL_W;

  typedef logic [LU_CODE_W-1:0] lu_code_t;

  typedef enum logic [3:0] {
    LU_ZERO,
    LU_AND,
    LU_OR,
    LU_XOR,
    LU_NAND,
    LU_NOR,
    LU_XNOR,
    LU_PASS_X,
    LU_PASS_Y,
    LU_NOT_X,
    LU_NOT_Y,
    LU_ONE
  } lu_op_e;

  // code bit index = {y,x}
  function automatic lu_code_t lu_decode(lu_op_e op);
    lu_code_t c;
    case (op)
      LU_AND:    c = 4'b1000;
      LU_OR:     c = 4'b1110;
      LU_XOR:    c = 4'b0110;
      LU_NAND:   c = 4'b0111;
      LU_NOR:    c = 4'b0001;
      LU_XNOR:   c = 4'b1001;
      LU_PASS_X: c = 4'b1010;
      LU_PASS_Y: c = 4'b1100;
      LU_NOT_X:  c = 4'b0101;
      LU_NOT_Y:  c = 4'b0011;
      LU_ONE:    c = 4'b1111;
      default:   c = 4'b0000;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lu_mux2.sv
module lu_mux2 (
  input  logic d0_i,
  input  logic d1_i,
  input  logic sel_i,
  output logic d_o
);
  assign d_o = sel_i ? d1_i : d0_i;
endmodule

// File: rtl/lu_bit_slice.sv
module lu_bit_slice
  import lu_pkg::*;
(
  input  logic     x_i,
  input  logic     y_i,
  input  lu_code_t code_i,
  output logic     z_o
);
  localparam int unsigned PAIRS = LU_CODE_W / 2;

  logic [PAIRS-1:0] lvl1;

  // first level: x picks within each pair
  for (genvar p = 0; p < PAIRS; p++) begin : g_lvl1
    lu_mux2 u_mux (
      .d0_i (code_i[2*p]),
      .d1_i (code_i[2*p+1]),
      .sel_i(x_i),
      .d_o  (lvl1[p])
    );
  end

  // second level: y picks the pair
  lu_mux2 u_mux_top (
    .d0_i (lvl1[0]),
    .d1_i (lvl1[1]),
    .sel_i(y_i),
    .d_o  (z_o)
  );

  always_comb begin : p_chk
    AST_SLICE_SELECT: assert (z_o == code_i[{y_i, x_i}]) else $error("slice select mismatch"); // R1
  end
endmodule

// File: rtl/mux_logic_unit.sv
module mux_logic_unit
  import lu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]     x_i,
  input  logic [WIDTH-1:0]     y_i,
  input  logic [LU_CODE_W-1:0] func_i,
  output logic [WIDTH-1:0]     res_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    lu_bit_slice u_slice (
      .x_i   (x_i[i]),
      .y_i   (y_i[i]),
      .code_i(func_i),
      .z_o   (res_o[i])
    );
  end

  always_comb begin : p_chk
    if (func_i == 4'b1000) AST_FN_AND:  assert (res_o == (x_i & y_i)) else $error("AND");      // R3
    if (func_i == 4'b1110) AST_FN_OR:   assert (res_o == (x_i | y_i)) else $error("OR");       // R4
    if (func_i == 4'b0110) AST_FN_XOR:  assert (res_o == (x_i ^ y_i)) else $error("XOR");      // R5
    if (func_i == 4'b0111) AST_FN_NAND: assert (res_o == ~(x_i & y_i)) else $error("NAND");    // R6
    if (func_i == 4'b0000) AST_FN_ZERO: assert (res_o == '0) else $error("ZERO");              // R7
    if (func_i == 4'b1111) AST_FN_ONE:  assert (res_o == ALL_ONES) else $error("ONE");         // R7
    if (func_i == 4'b1010) AST_FN_PASS_X: assert (res_o == x_i) else $error("PASS_X");         // R8
    if (func_i == 4'b1100) AST_FN_PASS_Y: assert (res_o == y_i) else $error("PASS_Y");         // R8
  end
endmodule

// File: tb/mux_logic_unit_tb.sv
module mux_logic_unit_tb;
  import lu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [7:0] wx, wy, wres;
  logic [3:0] wcode;
  logic [3:0] nx, ny, nres;
  logic [3:0] ncode;

  mux_logic_unit #(.WIDTH(8)) u_dut (
    .x_i(wx), .y_i(wy), .func_i(wcode), .res_o(wres)
  );

  mux_logic_unit #(.WIDTH(4)) u_dut_narrow (
    .x_i(nx), .y_i(ny), .func_i(ncode), .res_o(nres)
  );

  // truth-table reference: bit i takes code[2*y + x]
  function automatic logic [7:0] ref_fn(logic [3:0] code, logic [7:0] a, logic [7:0] b, int w);
    logic [7:0] r = '0;
    for (int i = 0; i < w; i++) begin
      int idx = 2 * int'(b[i]) + int'(a[i]);
      r[i] = code[idx];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_wide(logic [3:0] code, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    wcode = code; wx = a; wy = b;
    #(CLK_PERIOD/4);
  endtask

  task automatic drive_narrow(logic [3:0] code, logic [3:0] a, logic [3:0] b);
    @(negedge clk);
    ncode = code; nx = a; ny = b;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    wx = '0; wy = '0; wcode = '0;
    nx = '0; ny = '0; ncode = '0;

    // idle state: zero code, zero operands
    drive_wide(4'b0000, 8'h00, 8'h00);
    chk("R7 idle", wres, 8'h00);

    // R1: single-bit select mapping, slice 0, code with distinct legs
    drive_wide(4'b0010, 8'h01, 8'h00);
    chk("R1 x=1 y=0 picks bit1", wres, 8'h01);
    drive_wide(4'b0100, 8'h00, 8'h01);
    chk("R1 x=0 y=1 picks bit2", wres, 8'h01);
    drive_wide(4'b0010, 8'h00, 8'h01);
    chk("R1 x=0 y=1 ignores bit1", wres, 8'h00);

    // named ops with the mixed pattern and the decode helper
    chk("R3 decode", {4'h0, lu_decode(LU_AND)},  8'b1000);
    chk("R4 decode", {4'h0, lu_decode(LU_OR)},   8'b1110);
    chk("R5 decode", {4'h0, lu_decode(LU_XOR)},  8'b0110);
    chk("R6 decode", {4'h0, lu_decode(LU_NAND)}, 8'b0111);
    drive_wide(4'b1000, 8'h55, 8'h33); chk("R3 AND",  wres, 8'h11);
    drive_wide(4'b1110, 8'h55, 8'h33); chk("R4 OR",   wres, 8'h77);
    drive_wide(4'b0110, 8'h55, 8'h33); chk("R5 XOR",  wres, 8'h66);
    drive_wide(4'b0111, 8'h55, 8'h33); chk("R6 NAND", wres, 8'hEE);
    drive_wide(4'b0000, 8'hFF, 8'hFF); chk("R7 zero", wres, 8'h00);
    drive_wide(4'b1111, 8'h00, 8'h00); chk("R7 one",  wres, 8'hFF);
    drive_wide(4'b1010, 8'hA6, 8'h3C); chk("R8 pass x", wres, 8'hA6);
    drive_wide(4'b1100, 8'hA6, 8'h3C); chk("R8 pass y", wres, 8'h3C);

    // R2: all codes, random 8-bit operands against the reference
    for (int c = 0; c < 16; c++) begin
      for (int n = 0; n < 64; n++) begin
        logic [7:0] a = 8'($urandom);
        logic [7:0] b = 8'($urandom);
        drive_wide(4'(c), a, b);
        chk("R2 random", wres, ref_fn(4'(c), a, b, 8));
      end
    end

    // R9: 4-bit instance, exhaustive operands under every code
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          drive_narrow(4'(c), 4'(a), 4'(b));
          chk("R9 narrow", {4'h0, nres}, ref_fn(4'(c), 8'(a), 8'(b), 4));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int t = 0; t < WATCHDOG; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule